// File: doc/BRIEF.md
# Convolution Processing-Element Grid with Neighbour Pixel Sharing

This block is a square grid of multiply-accumulate elements for the inference stage of a convolutional network. Each element produces one output pixel of an N by N output tile. A controller walks the taps of a KW by KH kernel in raster order. On every tap it reads one weight from an on-chip weight store and applies it to all elements at once. When the last tap has been accumulated, the whole tile is presented on one wide output bus in a single cycle, marked by a one-cycle valid pulse.

Input pixels come from an on-chip pixel store that holds an (N+KW-1) by (N+KH-1) input tile. The store is only read in full on the first tap. After that, pixels are passed between elements through two small FIFOs per element, one for horizontal sharing and one for vertical sharing. On a column-shift tap, only the rightmost column reads the store and every other element pops the horizontal FIFO of its right neighbour. On a row-shift tap, which starts a new kernel row, only the bottom row reads the store and every other element pops the vertical FIFO of the element below it.

The controller has three states. `ST_IDLE` waits for `start` and moves to `ST_RUN`, clearing the accumulators. `ST_RUN` issues one tap per cycle and moves to `ST_DONE` on the last tap. `ST_DONE` raises `out_valid` and returns to `ST_IDLE` on the next cycle. The weight and pixel stores are filled through simple write ports.

Top module: `cnv_grid`

## Requirements
- R1: After reset, `busy` is 0, `out_valid` is 0 and every bit of `out_data` is 0.
- R2: A `start` sampled in ST_IDLE clears all accumulators. `busy` is then high for exactly KW*KH+1 cycles, beginning with the cycle after that edge.
- R3: `out_valid` is high for exactly one cycle, and that cycle begins KW*KH clock edges after the edge that sampled `start`. In that cycle, lane r*N+c of `out_data` (bits [(r*N+c)*AW +: AW], signed) holds the result of element (r,c).
- R4: Weight store word ky*KW+kx is the kernel tap (ky,kx) and is applied to every element together. Pixel store word y*TW+x, with TW=N+KW-1, holds the input pixel at row y and column x. Element (r,c) produces the sum over all taps of W(ky,kx)*P(r+ky,c+kx).
- R5: The first tap loads every element from the pixel store. A tap with kx>0 loads only the right column from the store, and every other element takes its right neighbour's horizontal FIFO head. A tap with kx=0 and ky>0 loads only the bottom row from the store, and every other element takes its lower neighbour's vertical FIFO head. Results are correct for tiles in which every pixel value differs.
- R6: Each accumulation step adds the signed DW×DW product to the AW-bit accumulator and clamps to the largest or smallest AW-bit value on overflow. Steps are applied tap by tap in raster order, so a clamped sum can later move back into range.
- R7: A `start` that arrives while `busy` is high is ignored. The run in progress keeps its timing and its results.
- R8: After the valid cycle, `out_data` holds its value until the next accepted `start`. Writes to either store in the meantime do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a tile when idle |
| wgt_we | input | 1 | Weight store write enable |
| wgt_addr | input | WAW | Weight store word address (ky*KW+kx) |
| wgt_wdata | input | DW | Signed weight to write |
| pix_we | input | 1 | Pixel store write enable |
| pix_addr | input | PAW | Pixel store word address (y*TW+x) |
| pix_wdata | input | DW | Signed pixel to write |
| busy | output | 1 | High from an accepted start through the valid cycle |
| out_valid | output | 1 | One-cycle pulse marking a finished tile |
| out_data | output | N*N*AW | All element results, lane r*N+c |

## Verification
The hardest case to reach from the ports is a wrong neighbour hand-off. If a horizontal or vertical FIFO is popped from the wrong side or not flushed at a row start, an element sees a stale pixel. With a uniform tile this still gives the right sum. The stimulus therefore uses a ramp tile, where every pixel differs and each weight is distinct, together with seeded random tiles. Any misrouted pixel then changes a sum. Frames whose full-range values drive the accumulators into and back out of saturation check the tap-by-tap clamping order against a reference convolution that saturates at each step.

// File: rtl/cnv_pkg.sv
package cnv_pkg;

    // Source of the pixel that each element consumes on a tap
    typedef enum logic [1:0] {
        LD_NONE = 2'd0,
        LD_FULL = 2'd1,
        LD_COL  = 2'd2,
        LD_ROW  = 2'd3
    } ld_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } ctl_state_e;

endpackage

// File: rtl/cnv_ctrl.sv
module cnv_ctrl
    import cnv_pkg::*;
#(
    parameter int KW = 3,
    parameter int KH = 3,
    localparam int KXW = (KW > 1) ? $clog2(KW) : 1,
    localparam int KYW = (KH > 1) ? $clog2(KH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    output ld_mode_e       mode,
    output logic [KXW-1:0] tap_kx,
    output logic [KYW-1:0] tap_ky,
    output logic           mac_en,
    output logic           acc_clr,
    output logic           busy,
    output logic           out_valid
);

    localparam logic [KXW-1:0] KX_LAST = KXW'(KW - 1);
    localparam logic [KYW-1:0] KY_LAST = KYW'(KH - 1);

    ctl_state_e state, state_nx;
    logic       last_tap;

    assign last_tap = (tap_kx == KX_LAST) && (tap_ky == KY_LAST);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start)    state_nx = ST_RUN;
            ST_RUN:  if (last_tap) state_nx = ST_DONE;
            ST_DONE:               state_nx = ST_IDLE;
            default:               state_nx = ST_IDLE;
        endcase
    end

    // tap counters walk the kernel in raster order
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tap_kx <= '0;
            tap_ky <= '0;
        end else if (state == ST_RUN) begin
            if (tap_kx == KX_LAST) begin
                tap_kx <= '0;
                tap_ky <= (tap_ky == KY_LAST) ? '0 : tap_ky + 1'b1;
            end else begin
                tap_kx <= tap_kx + 1'b1;
            end
        end else begin
            tap_kx <= '0;
            tap_ky <= '0;
        end
    end

    // outputs
    always_comb begin
        mode      = LD_NONE;
        mac_en    = 1'b0;
        acc_clr   = 1'b0;
        busy      = 1'b1;
        out_valid = 1'b0;
        unique case (state)
            ST_IDLE: begin
                busy    = 1'b0;
                acc_clr = start;
            end
            ST_RUN: begin
                mac_en = 1'b1;
                if (tap_kx != '0)      mode = LD_COL;
                else if (tap_ky != '0) mode = LD_ROW;
                else                   mode = LD_FULL;
            end
            ST_DONE: out_valid = 1'b1;
            default: busy = 1'b0;
        endcase
    end

endmodule

// File: rtl/cnv_fifo.sv
module cnv_fifo #(
    parameter int DW = 16,
    parameter int QD = 3,
    localparam int QC = $clog2(QD + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 flush,
    input  logic                 push,
    input  logic                 pop,
    input  logic signed [DW-1:0] din,
    output logic signed [DW-1:0] head
);

    logic signed [DW-1:0] q    [QD];
    logic signed [DW-1:0] q_nx [QD];
    logic [QC-1:0]        cnt, cnt_nx;

    always_comb begin
        for (int i = 0; i < QD; i++) q_nx[i] = q[i];
        cnt_nx = cnt;
        if (flush) begin
            cnt_nx = '0;
        end else if (pop && (cnt != '0)) begin
            for (int i = 0; i < QD - 1; i++) q_nx[i] = q[i+1];
            cnt_nx = cnt - 1'b1;
        end
        if (push && (cnt_nx < QC'(QD))) begin
            for (int i = 0; i < QD; i++) begin
                if (QC'(i) == cnt_nx) q_nx[i] = din;
            end
            cnt_nx = cnt_nx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            for (int i = 0; i < QD; i++) q[i] <= '0;
        end else begin
            cnt <= cnt_nx;
            for (int i = 0; i < QD; i++) q[i] <= q_nx[i];
        end
    end

    assign head = q[0];

endmodule

// File: rtl/cnv_cell.sv
module cnv_cell #(
    parameter int DW = 16,
    parameter int AW = 32,
    parameter int QD = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 acc_clr,
    input  logic                 mac_en,
    input  logic                 h_pop,
    input  logic                 h_flush,
    input  logic                 v_push,
    input  logic                 v_pop,
    input  logic signed [DW-1:0] pix,
    input  logic signed [DW-1:0] wgt,
    output logic signed [DW-1:0] h_head,
    output logic signed [DW-1:0] v_head,
    output logic signed [AW-1:0] acc
);

    localparam int PW = 2 * DW;

    logic signed [PW-1:0] prod;
    logic signed [AW:0]   sum_w;
    logic signed [AW-1:0] sum_sat;

    assign prod  = pix * wgt;
    assign sum_w = {acc[AW-1], acc} + {{(AW + 1 - PW){prod[PW-1]}}, prod};

    always_comb begin
        if (sum_w[AW] != sum_w[AW-1])
            sum_sat = sum_w[AW] ? {1'b1, {(AW-1){1'b0}}} : {1'b0, {(AW-1){1'b1}}};
        else
            sum_sat = sum_w[AW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       acc <= '0;
        else if (acc_clr) acc <= '0;
        else if (mac_en)  acc <= sum_sat;
    end

    // horizontal sharing: every consumed pixel, handed to the left neighbour
    cnv_fifo #(.DW(DW), .QD(QD)) u_hq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (acc_clr | h_flush),
        .push  (mac_en),
        .pop   (h_pop),
        .din   (pix),
        .head  (h_head)
    );

    // vertical sharing: first pixel of each kernel row, handed upward
    cnv_fifo #(.DW(DW), .QD(QD)) u_vq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (acc_clr),
        .push  (v_push),
        .pop   (v_pop),
        .din   (pix),
        .head  (v_head)
    );

endmodule

// File: rtl/cnv_grid.sv
module cnv_grid
    import cnv_pkg::*;
#(
    parameter int N  = 4,
    parameter int KW = 3,
    parameter int KH = 3,
    parameter int DW = 16,
    parameter int AW = 32,
    localparam int TW  = N + KW - 1,
    localparam int TH  = N + KH - 1,
    localparam int WD  = KW * KH,
    localparam int PD  = TW * TH,
    localparam int WAW = (WD > 1) ? $clog2(WD) : 1,
    localparam int PAW = (PD > 1) ? $clog2(PD) : 1,
    localparam int KXW = (KW > 1) ? $clog2(KW) : 1,
    localparam int KYW = (KH > 1) ? $clog2(KH) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                wgt_we,
    input  logic [WAW-1:0]      wgt_addr,
    input  logic [DW-1:0]       wgt_wdata,
    input  logic                pix_we,
    input  logic [PAW-1:0]      pix_addr,
    input  logic [DW-1:0]       pix_wdata,
    output logic                busy,
    output logic                out_valid,
    output logic [N*N*AW-1:0]   out_data
);

    logic signed [DW-1:0] wgt_mem [WD];
    logic signed [DW-1:0] pix_mem [PD];

    ld_mode_e       mode;
    logic [KXW-1:0] tap_kx;
    logic [KYW-1:0] tap_ky;
    logic           mac_en;
    logic           acc_clr;

    logic signed [DW-1:0] wgt_b;
    logic [WAW-1:0]       wgt_ra;

    logic signed [DW-1:0] hq_head [N][N];
    logic signed [DW-1:0] vq_head [N][N];
    logic signed [AW-1:0] acc     [N][N];

    // on-chip stores
    always_ff @(posedge clk) begin
        if (wgt_we) wgt_mem[wgt_addr] <= wgt_wdata;
        if (pix_we) pix_mem[pix_addr] <= pix_wdata;
    end

    cnv_ctrl #(.KW(KW), .KH(KH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .mode      (mode),
        .tap_kx    (tap_kx),
        .tap_ky    (tap_ky),
        .mac_en    (mac_en),
        .acc_clr   (acc_clr),
        .busy      (busy),
        .out_valid (out_valid)
    );

    // one weight per tap, broadcast to the whole grid
    assign wgt_ra = WAW'(int'(tap_ky) * KW + int'(tap_kx));
    assign wgt_b  = wgt_mem[wgt_ra];

    for (genvar r = 0; r < N; r++) begin : g_row
        for (genvar c = 0; c < N; c++) begin : g_col
            logic signed [DW-1:0] pix_sel;
            logic signed [DW-1:0] nb_h;
            logic signed [DW-1:0] nb_v;
            logic [PAW-1:0]       ix_full;

            assign ix_full = PAW'(r * TW + c);

            if (c < N - 1) begin : g_hn
                assign nb_h = hq_head[r][c+1];
            end else begin : g_he
                logic [PAW-1:0] ix_col;
                assign ix_col = PAW'((r + int'(tap_ky)) * TW + c + int'(tap_kx));
                assign nb_h   = pix_mem[ix_col];
            end

            if (r < N - 1) begin : g_vn
                assign nb_v = vq_head[r+1][c];
            end else begin : g_ve
                logic [PAW-1:0] ix_row;
                assign ix_row = PAW'((r + int'(tap_ky)) * TW + c);
                assign nb_v   = pix_mem[ix_row];
            end

            always_comb begin
                unique case (mode)
                    LD_FULL: pix_sel = pix_mem[ix_full];
                    LD_COL:  pix_sel = nb_h;
                    LD_ROW:  pix_sel = nb_v;
                    default: pix_sel = '0;
                endcase
            end

            cnv_cell #(.DW(DW), .AW(AW), .QD(KW)) u_cell (
                .clk     (clk),
                .rst_n   (rst_n),
                .acc_clr (acc_clr),
                .mac_en  (mac_en),
                .h_pop   (mode == LD_COL),
                .h_flush (mode == LD_FULL || mode == LD_ROW),
                .v_push  (mac_en && (tap_kx == '0)),
                .v_pop   (mode == LD_ROW),
                .pix     (pix_sel),
                .wgt     (wgt_b),
                .h_head  (hq_head[r][c]),
                .v_head  (vq_head[r][c]),
                .acc     (acc[r][c])
            );

            assign out_data[(r*N+c)*AW +: AW] = acc[r][c];
        end
    end

endmodule

// File: rtl/cnv_grid_chk.sv
module cnv_grid_chk
    import cnv_pkg::*;
#(
    parameter int N  = 4,
    parameter int KW = 3,
    parameter int KH = 3,
    parameter int AW = 32,
    localparam int KXW = (KW > 1) ? $clog2(KW) : 1,
    localparam int KYW = (KH > 1) ? $clog2(KH) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              out_valid,
    input logic [N*N*AW-1:0] out_data,
    input ld_mode_e          mode,
    input logic [KXW-1:0]    tap_kx,
    input logic [KYW-1:0]    tap_ky
);

    localparam int KK = KW * KH;

    // cycles since the accepted start, 0 when no run is active
    logic [15:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   run_cnt <= '0;
        else if (start && !busy)      run_cnt <= 16'd1;
        else if (run_cnt == 16'(KK + 1)) run_cnt <= '0;
        else if (run_cnt != '0)       run_cnt <= run_cnt + 16'd1;
    end

    assert_valid_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    assert_valid_timing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == (run_cnt == 16'(KK + 1)));

    assert_busy_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy == (run_cnt != '0));

    assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (out_data == '0));

    assert_first_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (mode == LD_FULL));

    assert_row_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == LD_ROW) |-> (tap_kx == '0 && tap_ky != '0));

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(out_data));

endmodule

bind cnv_grid cnv_grid_chk #(.N(N), .KW(KW), .KH(KH), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .out_valid (out_valid),
    .out_data  (out_data),
    .mode      (mode),
    .tap_kx    (tap_kx),
    .tap_ky    (tap_ky)
);

// File: tb/cnv_grid_test.sv
`timescale 1ns/1ps
module cnv_grid_test;

    localparam int N   = 4;
    localparam int KW  = 3;
    localparam int KH  = 3;
    localparam int DW  = 16;
    localparam int AW  = 32;
    localparam int TW  = N + KW - 1;
    localparam int TH  = N + KH - 1;
    localparam int KK  = KW * KH;
    localparam int PD  = TW * TH;
    localparam int WAW = $clog2(KK);
    localparam int PAW = $clog2(PD);
    localparam longint SMAX = 64'sd2147483647;
    localparam longint SMIN = -64'sd2147483648;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              wgt_we = 1'b0;
    logic [WAW-1:0]    wgt_addr = '0;
    logic [DW-1:0]     wgt_wdata = '0;
    logic              pix_we = 1'b0;
    logic [PAW-1:0]    pix_addr = '0;
    logic [DW-1:0]     pix_wdata = '0;
    logic              busy;
    logic              out_valid;
    logic [N*N*AW-1:0] out_data;

    int     wv [KK];
    int     pv [PD];
    longint exp_q [N*N];
    int     n_chk = 0;
    int     n_err = 0;
    bit     finished = 1'b0;

    always #2 clk = ~clk;

    cnv_grid #(.N(N), .KW(KW), .KH(KH), .DW(DW), .AW(AW)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .wgt_we    (wgt_we),
        .wgt_addr  (wgt_addr),
        .wgt_wdata (wgt_wdata),
        .pix_we    (pix_we),
        .pix_addr  (pix_addr),
        .pix_wdata (pix_wdata),
        .busy      (busy),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    function automatic longint clamp(longint v);
        if (v > SMAX) return SMAX;
        if (v < SMIN) return SMIN;
        return v;
    endfunction

    function automatic longint lane(int i);
        return longint'($signed(out_data[i*AW +: AW]));
    endfunction

    // reference convolution with per-step clamping in raster order (R4, R6)
    task automatic compute_ref();
        for (int r = 0; r < N; r++) begin
            for (int c = 0; c < N; c++) begin
                longint a = 0;
                for (int ky = 0; ky < KH; ky++)
                    for (int kx = 0; kx < KW; kx++)
                        a = clamp(a + longint'(wv[ky*KW+kx]) * longint'(pv[(r+ky)*TW + c+kx]));
                exp_q[r*N+c] = a;
            end
        end
    endtask

    task automatic check(bit ok, string req, longint act, longint expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic load_all();
        for (int i = 0; i < KK; i++) begin
            @(negedge clk);
            wgt_we = 1'b1; wgt_addr = WAW'(i); wgt_wdata = DW'(wv[i]);
        end
        @(negedge clk) wgt_we = 1'b0;
        for (int i = 0; i < PD; i++) begin
            @(negedge clk);
            pix_we = 1'b1; pix_addr = PAW'(i); pix_wdata = DW'(pv[i]);
        end
        @(negedge clk) pix_we = 1'b0;
    endtask

    // run one tile; inject=1 pulses start again in the middle (R7)
    task automatic run_tile(bit inject, string tag);
        compute_ref();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        for (int k = 1; k <= KK; k++) begin
            @(negedge clk);
            start = inject && (k == 2);
            check(busy == 1'b1, "R2 busy during run", longint'(busy), 1);
            check(out_valid == (k == KK), inject ? "R7 valid timing" : "R3 valid timing",
                  longint'(out_valid), longint'(k == KK));
        end
        start = 1'b0;
        for (int i = 0; i < N*N; i++)
            check(lane(i) == exp_q[i], tag, lane(i), exp_q[i]);
        @(negedge clk);
        check(out_valid == 1'b0, "R3 single pulse", longint'(out_valid), 0);
        check(busy == 1'b0, "R2 busy length", longint'(busy), 0);
        check(lane(N*N-1) == exp_q[N*N-1], "R8 hold", lane(N*N-1), exp_q[N*N-1]);
    endtask

    task automatic fill_rand(int span);
        for (int i = 0; i < KK; i++) wv[i] = int'($urandom_range(2*span - 1)) - span;
        for (int i = 0; i < PD; i++) pv[i] = int'($urandom_range(2*span - 1)) - span;
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset values
        check(busy == 1'b0, "R1 busy", longint'(busy), 0);
        check(out_valid == 1'b0, "R1 valid", longint'(out_valid), 0);
        check(out_data == '0, "R1 data", longint'(out_data[AW-1:0]), 0);
        rst_n = 1'b1;

        // R4: all ones
        for (int i = 0; i < KK; i++) wv[i] = 1;
        for (int i = 0; i < PD; i++) pv[i] = 1;
        load_all();
        run_tile(1'b0, "R4 uniform");

        // R5: ramp, every pixel distinct, weights distinct
        for (int i = 0; i < KK; i++) wv[i] = i + 1;
        for (int i = 0; i < PD; i++) pv[i] = i * 7 - 100;
        load_all();
        // R8: store writes while idle leave the previous result untouched
        check(lane(0) == 9, "R8 writes ignored", lane(0), 9);
        run_tile(1'b0, "R5 ramp");

        // R2: second run restarts from cleared accumulators
        run_tile(1'b0, "R2 rerun");

        // R6: positive saturation
        for (int i = 0; i < KK; i++) wv[i] = -32768;
        for (int i = 0; i < PD; i++) pv[i] = -32768;
        load_all();
        run_tile(1'b0, "R6 pos clamp");

        // R6: negative saturation
        for (int i = 0; i < PD; i++) pv[i] = 32767;
        load_all();
        run_tile(1'b0, "R6 neg clamp");

        // R7: start while busy
        for (int i = 0; i < KK; i++) wv[i] = 3 - i;
        for (int i = 0; i < PD; i++) pv[i] = (i * 13) % 29;
        load_all();
        run_tile(1'b1, "R7 result");

        // R5/R6: seeded random, small then full range
        for (int t = 0; t < 6; t++) begin
            fill_rand((t < 3) ? 8 : 32768);
            load_all();
            run_tile(1'b0, (t < 3) ? "R5 random" : "R6 random");
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule